// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a 64-entry, 18-bit first-in first-out buffer that joins two clock domains. The producer side writes on its own free-running clock and the consumer side reads on a second one. The two clocks may be unrelated or may be the same net. Pointers cross between the domains in Gray code through two-stage synchronizers. Each side judges full or empty conservatively, so the storage can neither overflow nor underflow.

The consumer never has to ask for the first word. When a word lands in an empty buffer, it moves to the output register by itself and the output-ready flag rises. After that, each qualified read retires the word on show and presents the next one. The write domain also drives two occupancy flags: a half-full flag, and one flag that marks both near-empty and near-full. The two thresholds of that second flag are 8 by default. They can be reloaded from the data bus after reset, before any data is written. The output-enable pair does two things: it blocks reads, and it drives an output-valid strobe that stands in for tri-state drive.

Top module: `dcfifo_ft`

## Requirements
- R1: A word is stored at a rising `wclk_i` edge only when `wr_en_i`=1, `wr_inh_i`=0 and `in_rdy_o`=1. Stored words leave in the order they were stored, with their values unchanged.
- R2: `in_rdy_o` is 0 while `rst_ni` is 0. It is still 0 after the first rising `wclk_i` edge after reset release, and it is 1 after the second.
- R3: Once 64 words are held and none has been retired, `in_rdy_o` is 0 and further write attempts store nothing.
- R4: The first write into an empty buffer makes `out_rdy_o`=1 and puts that word on `rdata_o` at the third rising `rclk_i` edge after the write edge. Before that edge `out_rdy_o` stays 0. This happens whatever the levels of `rd_en_ni`, `oe_a_ni` and `oe_b_ni`.
- R5: A word is retired at a rising `rclk_i` edge only when `rd_en_ni`, `oe_a_ni` and `oe_b_ni` are all 0 and `out_rdy_o` is 1. If another word is held, it appears on `rdata_o` at the same edge.
- R6: When the last held word is retired, `out_rdy_o` falls. While `out_rdy_o` is 0, `rdata_o` keeps the last retired word.
- R7: `rdata_oe_o` is 1 exactly when `oe_a_ni` and `oe_b_ni` are both 0. While either is 1, no word is retired and `rdata_o` does not change.
- R8: While `rst_ni` is 0: `in_rdy_o`=0, `out_rdy_o`=0, `half_o`=0 and `almost_o`=1.
- R9: Once the pointers have settled, `half_o` is 1 exactly when the held count is 32 or more. The held count is words stored minus words retired, and it includes the word on show.
- R10: Once settled, `almost_o` is 1 exactly when count <= X or count >= 64 - Y. After reset, X and Y are both 8.
- R11: After reset and before the first stored word, each rising `wclk_i` edge with `prog_ni`=0 takes `wdata_i[7:0]` as a threshold. The first such edge loads X and the second loads Y; later ones are ignored. A `prog_ni`=0 edge that coincides with the first stored word, or comes after it, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request, active high |
| wr_inh_i | input | 1 | Write inhibit, must be low to write |
| prog_ni | input | 1 | Threshold load strobe, active low |
| wdata_i | input | 18 | Write data; low 8 bits carry thresholds |
| in_rdy_o | output | 1 | Space available, write domain |
| half_o | output | 1 | Count at or above half depth |
| almost_o | output | 1 | Count near empty or near full |
| rd_en_ni | input | 1 | Read request, active low |
| oe_a_ni | input | 1 | Output enable A, active low |
| oe_b_ni | input | 1 | Output enable B, active low |
| rdata_o | output | 18 | Word on show |
| rdata_oe_o | output | 1 | Output would be driven |
| out_rdy_o | output | 1 | Valid word on show, read domain |

## Verification
The risky coincidence is a threshold load strobe landing on the same write edge as the first stored word. The bench provokes it right after a reset by raising the write request and lowering `prog_ni` together with a small value on the low data bits. It then fills to a count that is above that value but not above the default of 8. There it expects `almost_o` still high: the load was dropped and the data word was kept, and that word must later come out in order. A second pairing, where the last word is retired while new words are still crossing the synchronizers, arises many times in the seeded random traffic. There every retired value is compared against a reference queue.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  parameter int DEPTH       = 64;
  parameter int DW          = 18;
  parameter int OFS_W       = 8;
  parameter int SYNC_STAGES = 2;
  parameter int OFS_DFLT    = 8;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  typedef logic [DW-1:0]    word_t;
  typedef logic [PW-1:0]    ptr_t;
  typedef logic [AW-1:0]    addr_t;
  typedef logic [OFS_W-1:0] ofs_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram
  import dcfifo_pkg::*;
(
  input  logic  wclk_i,
  input  logic  we_i,
  input  addr_t waddr_i,
  input  word_t wdata_i,
  input  addr_t raddr_i,
  output word_t rdata_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr
  import dcfifo_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  wr_inh_i,
  input  logic  prog_ni,
  input  ofs_t  ofs_i,
  input  ptr_t  rgray_i,
  output logic  we_o,
  output addr_t waddr_o,
  output ptr_t  wgray_o,
  output logic  in_rdy_o,
  output logic  half_o,
  output logic  almost_o
);
  localparam int SW = ((PW > OFS_W) ? PW : OFS_W) + 1;

  logic       live, full_q, half_q, almost_q, wr_seen_q, do_wr, prog_ok, almost_nx;
  logic [1:0] prog_cnt_q;
  ptr_t       wptr_q, wptr_nx, rptr_bin, cnt_nx, wgray_q;
  ofs_t       ofs_x_q, ofs_y_q;
  logic [SW-1:0] hi_sum;

  dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(live)
  );

  assign in_rdy_o = live & ~full_q;
  assign do_wr    = wr_en_i & ~wr_inh_i & in_rdy_o;
  assign wptr_nx  = wptr_q + ptr_t'(do_wr);
  assign rptr_bin = gray2bin(rgray_i);
  assign cnt_nx   = wptr_nx - rptr_bin;
  assign hi_sum   = SW'(cnt_nx) + SW'(ofs_y_q);
  assign almost_nx = (SW'(cnt_nx) <= SW'(ofs_x_q)) || (hi_sum >= SW'(DEPTH));
  // thresholds load only before any data; a coincident write wins
  assign prog_ok  = live & ~prog_ni & ~wr_seen_q & ~do_wr & (prog_cnt_q < 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      wgray_q    <= '0;
      full_q     <= 1'b0;
      half_q     <= 1'b0;
      almost_q   <= 1'b1;
      wr_seen_q  <= 1'b0;
      prog_cnt_q <= '0;
      ofs_x_q    <= ofs_t'(OFS_DFLT);
      ofs_y_q    <= ofs_t'(OFS_DFLT);
    end else begin
      wptr_q   <= wptr_nx;
      wgray_q  <= bin2gray(wptr_nx);
      full_q   <= (cnt_nx == ptr_t'(DEPTH));
      half_q   <= (cnt_nx >= ptr_t'(DEPTH / 2));
      almost_q <= almost_nx;
      if (do_wr) wr_seen_q <= 1'b1;
      if (prog_ok) begin
        prog_cnt_q <= prog_cnt_q + 2'd1;
        if (prog_cnt_q == 2'd0) ofs_x_q <= ofs_i;
        else                    ofs_y_q <= ofs_i;
      end
    end
  end

  assign we_o     = do_wr;
  assign waddr_o  = wptr_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign half_o   = half_q;
  assign almost_o = almost_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wptr_q - rptr_bin) <= ptr_t'(DEPTH));
  a_r3_blocked_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rdy_o |=> wptr_q == $past(wptr_q));
  a_r1_write_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q != $past(wptr_q) |-> $past(wr_en_i && !wr_inh_i));
  a_r11_ofs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_seen_q) |-> ($stable(ofs_x_q) && $stable(ofs_y_q)));
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
  import dcfifo_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_en_ni,
  input  logic  oe_a_ni,
  input  logic  oe_b_ni,
  input  ptr_t  wgray_i,
  input  word_t mem_i,
  output addr_t raddr_o,
  output ptr_t  rgray_o,
  output word_t rdata_o,
  output logic  out_rdy_o
);
  logic  live, out_rdy_q, take;
  ptr_t  rptr_q, rptr_nx, wptr_bin, rgray_q;
  word_t dout_q;

  dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(live)
  );

  assign wptr_bin = gray2bin(wgray_i);
  assign take     = out_rdy_q & ~rd_en_ni & ~oe_a_ni & ~oe_b_ni;
  assign rptr_nx  = rptr_q + ptr_t'(1);
  // shown word sits at rptr; prefetch rptr+1 while one is shown
  assign raddr_o  = out_rdy_q ? rptr_nx[AW-1:0] : rptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q    <= '0;
      rgray_q   <= '0;
      dout_q    <= '0;
      out_rdy_q <= 1'b0;
    end else if (live) begin
      if (!out_rdy_q) begin
        if (rptr_q != wptr_bin) begin
          dout_q    <= mem_i;
          out_rdy_q <= 1'b1;
        end
      end else if (take) begin
        rptr_q  <= rptr_nx;
        rgray_q <= bin2gray(rptr_nx);
        if (rptr_nx != wptr_bin) dout_q    <= mem_i;
        else                     out_rdy_q <= 1'b0;
      end
    end
  end

  assign rgray_o   = rgray_q;
  assign rdata_o   = dout_q;
  assign out_rdy_o = out_rdy_q;

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rdy_o |-> rptr_q != wptr_bin);
  a_r5_retire_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_q != $past(rptr_q) |-> $past(out_rdy_o && !rd_en_ni && !oe_a_ni && !oe_b_ni));
  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_rdy_o |-> $stable(rdata_o));
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft
  import dcfifo_pkg::*;
(
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_inh_i,
  input  logic          prog_ni,
  input  logic [DW-1:0] wdata_i,
  output logic          in_rdy_o,
  output logic          half_o,
  output logic          almost_o,
  input  logic          rd_en_ni,
  input  logic          oe_a_ni,
  input  logic          oe_b_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o,
  output logic          out_rdy_o
);
  logic  we;
  addr_t waddr, raddr;
  ptr_t  wgray, rgray, wgray_r, rgray_w;
  word_t mem_rd;

  dcfifo_wr u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_inh_i(wr_inh_i),
    .prog_ni(prog_ni), .ofs_i(wdata_i[OFS_W-1:0]), .rgray_i(rgray_w),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .in_rdy_o(in_rdy_o),
    .half_o(half_o), .almost_o(almost_o)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_r)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_w)
  );

  dcfifo_ram u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rd)
  );

  dcfifo_rd u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rd_en_ni(rd_en_ni), .oe_a_ni(oe_a_ni),
    .oe_b_ni(oe_b_ni), .wgray_i(wgray_r), .mem_i(mem_rd), .raddr_o(raddr),
    .rgray_o(rgray), .rdata_o(rdata_o), .out_rdy_o(out_rdy_o)
  );

  assign rdata_oe_o = ~oe_a_ni & ~oe_b_ni;
endmodule

// File: tb/dcfifo_ft_tb_top.sv
module dcfifo_ft_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_inh = 1'b0, prog_n = 1'b1;
  logic [17:0] wdata = '0;
  logic        rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic        in_rdy, half, almost, out_rdy, rdata_oe;
  logic [17:0] rdata;

  int          checks = 0, fails = 0;
  logic [17:0] mq[$];
  logic [17:0] last_rd = '0;
  bit          have_last = 0, wr_seen = 0, done = 0;
  int          pcnt = 0, ox = 8, oy = 8;

  always #10 clk = ~clk;

  dcfifo_ft dut_i (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_inh_i(wr_inh),
    .prog_ni(prog_n), .wdata_i(wdata), .in_rdy_o(in_rdy), .half_o(half),
    .almost_o(almost), .rd_en_ni(rd_en_n), .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .out_rdy_o(out_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_almost(int sz);
    return (sz <= ox) || (sz >= 64 - oy);
  endfunction

  // one cycle: drive after negedge, judge, pass the posedge, land on next negedge
  task automatic cyc(input bit w, input bit wi, input bit rn, input bit oan,
                     input bit obn, input bit pn, input logic [17:0] d);
    bit wacc, racc;
    wr_en = w; wr_inh = wi; rd_en_n = rn; oe_a_n = oan; oe_b_n = obn;
    prog_n = pn; wdata = d;
    #1;
    wacc = w && !wi && in_rdy;
    racc = !rn && !oan && !obn && out_rdy;
    chk("R7 oe strobe", rdata_oe, 32'(!oan && !obn));
    if (racc) begin
      chk("R1/R5 retired word", rdata, mq[0]);
      last_rd = mq[0]; have_last = 1;
      void'(mq.pop_front());
    end
    if (!out_rdy && have_last) chk("R6 hold", rdata, last_rd);
    if (!pn && !wacc && !wr_seen && pcnt < 2) begin
      if (pcnt == 0) ox = int'(d[7:0]); else oy = int'(d[7:0]);
      pcnt++;
    end
    if (wacc) begin mq.push_back(d); wr_seen = 1; end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 1, 0, 0, 1, '0); endtask

  task automatic settle();
    repeat (4) idle();
    chk("R9 half", half, 32'(mq.size() >= 32));
    chk("R10 almost", almost, 32'(exp_almost(mq.size())));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 0; wr_inh = 0; prog_n = 1; rd_en_n = 1; oe_a_n = 1; oe_b_n = 1;
    repeat (5) @(negedge clk);
    chk("R8 in_rdy", in_rdy, 0);
    chk("R8 out_rdy", out_rdy, 0);
    chk("R8 half", half, 0);
    chk("R8 almost", almost, 1);
    mq.delete(); have_last = 0; wr_seen = 0; pcnt = 0; ox = 8; oy = 8;
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 first edge", in_rdy, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 second edge", in_rdy, 1);
  endtask

  task automatic drain();
    while (mq.size() > 0) cyc(0, 0, 0, 0, 0, 1, '0);
    idle();
    chk("R6 out_rdy after drain", out_rdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int sz;
    void'($urandom(32'd7411));

    // A: defaults, fall-through timing, output enables, fill and drain
    do_reset();
    cyc(1, 0, 0, 1, 1, 1, 18'h2A5A5);
    chk("R4 low after write edge", out_rdy, 0);
    cyc(0, 0, 0, 1, 0, 1, '0);
    cyc(0, 0, 0, 0, 1, 1, '0);
    chk("R4 low after edge 2", out_rdy, 0);
    cyc(0, 0, 0, 1, 1, 1, '0);
    chk("R4 high after edge 3", out_rdy, 1);
    chk("R4 word shown", rdata, 18'h2A5A5);
    repeat (3) cyc(0, 0, 0, 0, 1, 1, '0);
    chk("R7 blocked keeps ready", out_rdy, 1);
    chk("R7 blocked keeps word", rdata, 18'h2A5A5);
    cyc(0, 0, 0, 0, 0, 1, '0);
    chk("R6 falls on last", out_rdy, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 1, '0);

    for (int i = 0; i < 70; i++) begin
      sz = mq.size();
      cyc(1, 0, 1, 0, 0, 1, 18'(i * 977 + 3));
      if (mq.size() != sz) begin
        if (mq.size() == 64) chk("R3 full blocks", in_rdy, 0);
        if (mq.size() inside {8, 9, 31, 32, 55, 56, 64}) settle();
      end
    end
    chk("R3 accepted count", mq.size(), 64);
    while (mq.size() > 0) begin
      cyc(0, 0, 0, 0, 0, 1, '0);
      if (mq.size() inside {56, 55, 32, 31, 9, 8}) settle();
    end
    idle();
    chk("R6 out_rdy after drain", out_rdy, 0);
    settle();

    // B: thresholds X=3, Y=5, third strobe ignored
    do_reset();
    cyc(0, 0, 1, 0, 0, 0, 18'd3);
    cyc(0, 0, 1, 0, 0, 0, 18'd5);
    cyc(0, 0, 1, 0, 0, 0, 18'd20);
    for (int i = 0; i < 60; i++) begin
      cyc(1, 0, 1, 0, 0, 1, 18'(i + 100));
      if (mq.size() inside {3, 4, 58, 59}) settle();
    end
    chk("R11 X loaded", ox, 3);
    drain();

    // C: strobe on the first write edge and after it are ignored
    do_reset();
    cyc(1, 0, 1, 0, 0, 0, 18'h00002);
    cyc(1, 0, 1, 0, 0, 1, 18'h11111);
    cyc(1, 0, 1, 0, 0, 1, 18'h22222);
    settle();
    chk("R11 coincident strobe ignored", almost, 1);
    cyc(0, 0, 1, 0, 0, 0, 18'd1);
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 0, 1, 18'(i + 7));
    settle();
    chk("R11 late strobe ignored", almost, 0);
    drain();

    // D: seeded random traffic
    for (int k = 0; k < 3000; k++) begin
      cyc(1'($urandom % 2), 1'($urandom % 10 == 0), 1'($urandom % 2),
          1'($urandom % 8 == 0), 1'($urandom % 8 == 0), 1'($urandom % 10 != 0),
          18'($urandom));
      if (k % 250 == 249) settle();
    end
    drain();
    settle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule